// File: doc/BRIEF.md
# TDM Frame Format Detector and Bit Timing Unit

This block sits beside the serial ports of a time-slot switch. It runs from the 4.096 MHz bit clock and watches the 8 kHz frame pulse. From that pulse alone it works out which of two backplane framing conventions is in use: a pulse that goes low (ST-BUS) or a pulse that goes high (GCI). It reports the result, and it also reports which clock edge the ports must use as the bit boundary and which edge they must use to sample.

When the same kind of pulse arrives twice, exactly one frame of 512 clocks apart, the unit locks and aligns its timing to the second pulse. From then on it delivers the timing that the serial ports run on. Each bit has a shift strobe in its first clock and a sample strobe in its second clock. It also gives a bit index, a channel number and a strobe for the start of each frame. If a pulse goes missing, or a pulse of the other polarity appears, lock is lost and every strobe stays quiet.

Top module: `tdm_frame_timing`

## Requirements
- R1: Right after reset the unit is unlocked, reports ST-BUS (fmt_gci = 0), and keeps shift_en, sample_en and frame_start low.
- R2: A frame pulse is a run of the minority level lasting 1 to MAX_PW (default 2) clocks. A longer run is ignored and never leads to lock.
- R3: A pulse that is low reports ST-BUS (fmt_gci = 0). A pulse that is high reports GCI (fmt_gci = 1).
- R4: Lock is declared only when two pulses of the same polarity end exactly 512 clocks apart. Any other spacing, such as 511 clocks, leaves the unit unlocked.
- R5: While locked, if no pulse arrives 512 clocks after the previous one, lock falls in that same cycle.
- R6: A pulse whose polarity differs from the previous one drops lock and leaves fmt_gci unchanged. A second pulse of the new polarity, 512 clocks later, relocks with the new format.
- R7: In the cycle that lock is gained, frame_start and shift_en are 1 with channel 0 and bit 0. In the next cycle sample_en is 1 and shift_en is 0.
- R8: The bit index goes from 0 to 7, advancing every 2 clocks. The channel goes from 0 to 31, advancing every 16 clocks. frame_start repeats every 512 clocks.
- R9: bnd_on_fall is 1 for ST-BUS, meaning the boundary is on the falling edge and the sample is on the rising edge. It is 0 for GCI, meaning the reverse.
- R10: While unlocked, shift_en, sample_en and frame_start stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_in | input | 1 | Raw frame pulse from the backplane |
| locked | output | 1 | Format detected and timing aligned |
| fmt_gci | output | 1 | 1 = GCI framing (active-high pulse), 0 = ST-BUS |
| bnd_on_fall | output | 1 | 1 = bit boundary on the falling edge, sample on the rising edge |
| shift_en | output | 1 | Transmit-shift strobe, first clock of each bit |
| sample_en | output | 1 | Sample strobe, second clock of each bit |
| frame_start | output | 1 | First clock of channel 0, bit 0 |
| bit_idx | output | 3 | Bit position within the channel |
| chan | output | 5 | Channel number, 0 to 31 |

## Verification
A pulse is recognised at the clock edge where the input first returns to its idle level. That is one edge after the last clock at the pulse level. Lock, format and the reset of the counters all take effect at that same edge. The counters then advance one step per clock after it, so bit k of channel c falls exactly 16c + 2k clocks later, and a missing pulse drops lock exactly 512 clocks after the last pulse. The bench drives the pulse between edges and works out that event cycle from the pulse width. It queues each expected value with its absolute cycle number, and the monitor compares each one only in that cycle, sampling at the falling edge.

// File: rtl/tdm_fmt_pkg.sv
package tdm_fmt_pkg;

  typedef enum logic {
    FMT_STBUS = 1'b0,
    FMT_GCI   = 1'b1
  } fmt_e;

  // Clocks in one frame for the given channel, bit and clock-per-bit counts.
  function automatic int unsigned frame_len(input int unsigned chans,
                                            input int unsigned bits,
                                            input int unsigned cpb);
    return chans * bits * cpb;
  endfunction

  // A pulse at the high level means GCI framing; a low pulse means ST-BUS.
  function automatic fmt_e level_to_fmt(input logic lvl);
    return lvl ? FMT_GCI : FMT_STBUS;
  endfunction

  // In ST-BUS framing the bit boundary lies on the falling clock edge.
  function automatic logic boundary_on_fall(input fmt_e f);
    return (f == FMT_STBUS);
  endfunction

endpackage

// File: rtl/tfd_pulse_qual.sv
module tfd_pulse_qual
  import tdm_fmt_pkg::*;
#(
  parameter int unsigned MAX_PW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fp_in,
  output logic pulse_evt,
  output fmt_e pulse_pol
);
  localparam int unsigned RUN_W = $clog2(MAX_PW + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic             fp_q;
  logic [RUN_W-1:0] run_len;
  logic             lvl_change;

  assign lvl_change = (fp_in != fp_q);
  assign pulse_evt  = lvl_change && (run_len <= RUN_W'(MAX_PW));
  assign pulse_pol  = level_to_fmt(fp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fp_q    <= 1'b0;
      run_len <= RUN_MAX;
    end else begin
      fp_q <= fp_in;
      if (lvl_change)
        run_len <= RUN_W'(1);
      else if (run_len != RUN_MAX)
        run_len <= run_len + RUN_W'(1);
    end
  end

  // R2
  pulse_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_evt |-> (run_len != '0));

endmodule

// File: rtl/tfd_lock.sv
module tfd_lock
  import tdm_fmt_pkg::*;
#(
  parameter int unsigned FRAME_CLKS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_evt,
  input  fmt_e pulse_pol,
  output logic locked,
  output fmt_e fmt,
  output logic realign
);
  localparam int unsigned GAP_W = $clog2(FRAME_CLKS) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX  = '1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(FRAME_CLKS - 1);

  logic [GAP_W-1:0] gap;
  fmt_e             cand;

  assign realign = pulse_evt && (pulse_pol == cand) && (gap == GAP_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap    <= GAP_MAX;
      cand   <= FMT_STBUS;
      locked <= 1'b0;
      fmt    <= FMT_STBUS;
    end else if (pulse_evt) begin
      gap  <= '0;
      cand <= pulse_pol;
      if (realign) begin
        locked <= 1'b1;
        fmt    <= pulse_pol;
      end else begin
        locked <= 1'b0;
      end
    end else begin
      if (gap != GAP_MAX) gap <= gap + GAP_W'(1);
      if (gap == GAP_LAST) locked <= 1'b0;
    end
  end

  // R4
  lock_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(pulse_evt));

  // R6
  fmt_only_on_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fmt) |-> (locked && !$past(locked)));

endmodule

// File: rtl/tfd_slot_cnt.sv
module tfd_slot_cnt #(
  parameter int unsigned CHANNELS    = 32,
  parameter int unsigned BITS_PER_CH = 8,
  parameter int unsigned CLK_PER_BIT = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           realign,
  input  logic                           locked,
  output logic [$clog2(BITS_PER_CH)-1:0] bit_idx,
  output logic [$clog2(CHANNELS)-1:0]    chan,
  output logic                           shift_en,
  output logic                           sample_en,
  output logic                           frame_start
);
  localparam int unsigned PH_W = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;
  localparam int unsigned BI_W = $clog2(BITS_PER_CH);
  localparam int unsigned CH_W = $clog2(CHANNELS);

  logic [PH_W-1:0] phase;
  logic            last_ph, last_bit, last_ch;

  assign last_ph  = (phase == PH_W'(CLK_PER_BIT - 1));
  assign last_bit = (bit_idx == BI_W'(BITS_PER_CH - 1));
  assign last_ch  = (chan == CH_W'(CHANNELS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || realign) begin
      phase   <= '0;
      bit_idx <= '0;
      chan    <= '0;
    end else if (!last_ph) begin
      phase <= phase + PH_W'(1);
    end else begin
      phase <= '0;
      if (!last_bit) begin
        bit_idx <= bit_idx + BI_W'(1);
      end else begin
        bit_idx <= '0;
        chan    <= last_ch ? '0 : chan + CH_W'(1);
      end
    end
  end

  assign shift_en    = locked && (phase == '0);
  assign sample_en   = locked && last_ph;
  assign frame_start = locked && (phase == '0) && (bit_idx == '0) && (chan == '0);

  generate
    if (CLK_PER_BIT == 2) begin : g_two_phase
      // R7
      sample_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && $past(locked)) |-> $past(shift_en));
    end
  endgenerate

  // R8
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && last_ch && last_bit && last_ph && !realign) |=> (chan == '0 && bit_idx == '0));

endmodule

// File: rtl/tdm_frame_timing.sv
module tdm_frame_timing
  import tdm_fmt_pkg::*;
#(
  parameter int unsigned CHANNELS    = 32,
  parameter int unsigned BITS_PER_CH = 8,
  parameter int unsigned CLK_PER_BIT = 2,
  parameter int unsigned MAX_PW      = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fp_in,
  output logic                           locked,
  output logic                           fmt_gci,
  output logic                           bnd_on_fall,
  output logic                           shift_en,
  output logic                           sample_en,
  output logic                           frame_start,
  output logic [$clog2(BITS_PER_CH)-1:0] bit_idx,
  output logic [$clog2(CHANNELS)-1:0]    chan
);
  localparam int unsigned FRAME_CLKS = frame_len(CHANNELS, BITS_PER_CH, CLK_PER_BIT);

  logic pulse_evt;
  fmt_e pulse_pol;
  fmt_e fmt;
  logic realign;

  tfd_pulse_qual #(.MAX_PW(MAX_PW)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .fp_in     (fp_in),
    .pulse_evt (pulse_evt),
    .pulse_pol (pulse_pol)
  );

  tfd_lock #(.FRAME_CLKS(FRAME_CLKS)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_evt (pulse_evt),
    .pulse_pol (pulse_pol),
    .locked    (locked),
    .fmt       (fmt),
    .realign   (realign)
  );

  tfd_slot_cnt #(
    .CHANNELS    (CHANNELS),
    .BITS_PER_CH (BITS_PER_CH),
    .CLK_PER_BIT (CLK_PER_BIT)
  ) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .realign     (realign),
    .locked      (locked),
    .bit_idx     (bit_idx),
    .chan        (chan),
    .shift_en    (shift_en),
    .sample_en   (sample_en),
    .frame_start (frame_start)
  );

  assign fmt_gci     = (fmt == FMT_GCI);
  assign bnd_on_fall = boundary_on_fall(fmt);

  // R7
  lock_aligns_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (frame_start && shift_en));

  // R10
  quiet_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !(shift_en || sample_en || frame_start));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({shift_en, sample_en}) <= 1);

endmodule

// File: tb/test_tdm_frame_timing.sv
module test_tdm_frame_timing;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fp_in = 1'b1;
  logic       locked, fmt_gci, bnd_on_fall, shift_en, sample_en, frame_start;
  logic [2:0] bit_idx;
  logic [4:0] chan;

  tdm_frame_timing i_tdm_frame_timing (
    .clk(clk), .rst_n(rst_n), .fp_in(fp_in),
    .locked(locked), .fmt_gci(fmt_gci), .bnd_on_fall(bnd_on_fall),
    .shift_en(shift_en), .sample_en(sample_en), .frame_start(frame_start),
    .bit_idx(bit_idx), .chan(chan)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef enum int {K_LOCK, K_FMT, K_BND, K_FS, K_SHIFT, K_SAMPLE, K_BIT, K_CHAN} kind_e;
  typedef struct {
    int    at;
    kind_e kind;
    int    exp;
    string req;
  } item_t;
  item_t sb[$];

  function automatic int observe(kind_e k);
    case (k)
      K_LOCK:   return int'(locked);
      K_FMT:    return int'(fmt_gci);
      K_BND:    return int'(bnd_on_fall);
      K_FS:     return int'(frame_start);
      K_SHIFT:  return int'(shift_en);
      K_SAMPLE: return int'(sample_en);
      K_BIT:    return int'(bit_idx);
      default:  return int'(chan);
    endcase
  endfunction

  task automatic expect_at(int at, kind_e k, int e, string req);
    item_t it;
    it.at = at; it.kind = k; it.exp = e; it.req = req;
    sb.push_back(it);
  endtask

  task automatic check_now(kind_e k, int e, string req);
    tests++;
    if (observe(k) != e) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, k.name(), observe(k), e);
    end
  endtask

  // Monitor: compare each queued item in its own cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].at == cyc) begin
          tests++;
          if (observe(sb[i].kind) != sb[i].exp) begin
            fails++;
            $display("FAIL %s %s @%0d: got %0d expected %0d", sb[i].req,
                     sb[i].kind.name(), cyc, observe(sb[i].kind), sb[i].exp);
          end
          sb.delete(i);
        end
      end
    end
  end

  task automatic wait_to(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Drive a pulse of level lvl for w clocks; return the cycle it is recognised.
  task automatic pulse(input logic lvl, input int w, output int ev);
    int c;
    c = cyc;
    fp_in = lvl;
    repeat (w) @(negedge clk);
    fp_in = ~lvl;
    ev = c + w + 1;
  endtask

  task automatic finish_run();
    if (sb.size() != 0) begin
      fails += sb.size();
      tests += sb.size();
      $display("FAIL scoreboard: got %0d pending items expected 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int s, ea, eb, ec, ed, ee, ef, eg, eh, ei, ej, t;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_now(K_LOCK, 0, "R1");
    check_now(K_FMT, 0, "R1");
    check_now(K_SHIFT, 0, "R1");
    check_now(K_SAMPLE, 0, "R1");
    check_now(K_FS, 0, "R1");

    // ST-BUS: first pulse, then one 511 clocks later (wrong spacing), then a correct one.
    wait_to(20);
    s = cyc;
    pulse(1'b0, 1, ea);
    expect_at(ea, K_LOCK, 0, "R4");
    wait_to(s + 511);
    pulse(1'b0, 1, eb);
    expect_at(eb, K_LOCK, 0, "R4");
    expect_at(eb + 1, K_FS, 0, "R10");
    expect_at(eb + 1, K_SHIFT, 0, "R10");
    wait_to(s + 511 + 512);
    pulse(1'b0, 1, ec);
    expect_at(ec, K_LOCK, 1, "R4");
    expect_at(ec, K_FMT, 0, "R3");
    expect_at(ec, K_BND, 1, "R9");
    expect_at(ec, K_FS, 1, "R7");
    expect_at(ec, K_SHIFT, 1, "R7");
    expect_at(ec, K_BIT, 0, "R7");
    expect_at(ec, K_CHAN, 0, "R7");
    expect_at(ec + 1, K_SAMPLE, 1, "R7");
    expect_at(ec + 1, K_SHIFT, 0, "R7");
    expect_at(ec + 2, K_BIT, 1, "R8");
    expect_at(ec + 16, K_CHAN, 1, "R8");
    expect_at(ec + 16, K_BIT, 0, "R8");
    expect_at(ec + 511, K_CHAN, 31, "R8");
    expect_at(ec + 511, K_BIT, 7, "R8");
    expect_at(ec + 511, K_SAMPLE, 1, "R8");
    wait_to(s + 511 + 1024);
    pulse(1'b0, 1, ed);
    expect_at(ed, K_FS, 1, "R8");
    expect_at(ed, K_LOCK, 1, "R8");
    // No further pulse: lock must fall one frame later.
    expect_at(ed + 511, K_LOCK, 1, "R5");
    expect_at(ed + 512, K_LOCK, 0, "R5");
    expect_at(ed + 513, K_FS, 0, "R10");
    expect_at(ed + 513, K_SHIFT, 0, "R10");
    wait_to(ed + 520);

    // GCI: idle low. Wide pulses are ignored, narrow ones lock.
    fp_in = 1'b0;
    wait_to(cyc + 20);
    s = cyc;
    pulse(1'b1, 3, ee);
    expect_at(ee, K_LOCK, 0, "R2");
    wait_to(s + 512);
    pulse(1'b1, 3, ef);
    expect_at(ef, K_LOCK, 0, "R2");
    expect_at(ef + 3, K_LOCK, 0, "R2");
    wait_to(s + 1024);
    pulse(1'b1, 2, eg);
    expect_at(eg, K_LOCK, 0, "R2");
    wait_to(s + 1536);
    pulse(1'b1, 2, eh);
    expect_at(eh, K_LOCK, 1, "R2");
    expect_at(eh, K_FMT, 1, "R3");
    expect_at(eh, K_BND, 0, "R9");
    expect_at(eh, K_FS, 1, "R7");
    expect_at(eh, K_CHAN, 0, "R7");
    expect_at(eh + 1, K_SAMPLE, 1, "R7");

    // Polarity change: a low pulse drops lock, a second one relocks as ST-BUS.
    wait_to(eh + 100);
    fp_in = 1'b1;
    wait_to(cyc + 10);
    t = cyc;
    pulse(1'b0, 1, ei);
    expect_at(ei, K_LOCK, 0, "R6");
    expect_at(ei, K_FMT, 1, "R6");
    wait_to(t + 512);
    pulse(1'b0, 1, ej);
    expect_at(ej, K_LOCK, 1, "R6");
    expect_at(ej, K_FMT, 0, "R6");
    expect_at(ej, K_BND, 1, "R9");
    wait_to(ej + 10);

    done = 1'b1;
    finish_run();
  end

endmodule